// File: doc/BRIEF.md
# Chunk-Serial Mantissa Macro-Stage

This block is a single stage of a variable-precision floating-point pipeline whose datapath is only one 64-bit chunk wide. An operand arrives as a header (sign, flag bits, exponent, integer bits, used-chunk count) plus a mantissa of up to eight 64-bit chunks. The chunks arrive one per ready/valid beat, most significant chunk first. The stage stores the whole operand in a full-depth buffer. It then replays the chunks downstream over a second ready/valid link, copying each chunk unchanged.

A working-precision value travels beside the first beat and limits the result length. When the limit is below the input length, the trailing chunks are not sent. The leading bits of the first dropped chunk become the result's guard bits. Otherwise the guard bits that came with the last input chunk pass through unchanged.

The stage works store-and-forward, so its latency and its occupancy both grow with the number of chunks. A neighbouring stage sees the same handshake on both sides.

Top module: `chunk_stage`

## Requirements
- R1: After reset the input side is ready (`in_ready`=1) and no result is offered (`out_valid`=0).
- R2: Sign, flags, exponent, integer bits, length L (1..8) and working precision W (1..8) are sampled on the first beat of an operand. Exactly L input beats are accepted, and `in_ready` then falls.
- R3: The result has `out_len` = min(L, W) chunks. They are emitted in the order they were received, chunk 0 first, and `out_last` is set only on the final one.
- R4: `out_sign`, `out_flags`, `out_exp` and `out_ib` equal the values sampled on the first beat.
- R5: When W >= L, `out_gb` equals `in_gb` sampled on beat L-1. When W < L, `out_gb` equals bits [63:56] of input chunk number W, the most significant dropped chunk.
- R6: No input beat is accepted while a result is being emitted. `in_ready` returns to 1 in the cycle after the last output chunk is accepted.
- R7: While `out_valid`=1 and `out_ready`=0, the result and all its side fields stay unchanged.
- R8: Header, length and precision inputs on non-first beats are ignored, as is `in_gb` on beats other than beat L-1.
- R9: `out_valid` rises in the cycle after the L-th input handshake. An operand with no stalls occupies the stage for L + min(L, W) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input chunk valid |
| in_ready | output | 1 | Stage accepts an input chunk |
| in_data | input | 64 | Input mantissa chunk |
| in_len | input | 4 | Used chunk count L (first beat) |
| in_wp | input | 4 | Working precision in chunks (first beat) |
| in_sign | input | 1 | Sign (first beat) |
| in_flags | input | 4 | Special-value flags (first beat) |
| in_exp | input | 16 | Exponent (first beat) |
| in_ib | input | 2 | Integer bits (first beat) |
| in_gb | input | 8 | Guard bits of the last chunk (beat L-1) |
| out_valid | output | 1 | Output chunk valid |
| out_ready | input | 1 | Downstream accepts a chunk |
| out_data | output | 64 | Output mantissa chunk |
| out_len | output | 4 | Result chunk count |
| out_last | output | 1 | Final chunk of the result |
| out_sign | output | 1 | Result sign |
| out_flags | output | 4 | Result flags |
| out_exp | output | 16 | Result exponent |
| out_ib | output | 2 | Result integer bits |
| out_gb | output | 8 | Result guard bits |

## Verification
The in-module properties check several behaviours on every cycle:
- the result holds steady under backpressure;
- the input reopens right after the last output chunk;
- the result appears one cycle after the final input beat;
- header outputs do not move on non-first beats;
- sampled lengths and precisions stay in range.

Only the bench scenarios can show the rest:
- the chunk order and the min(L, W) clamp;
- the choice of guard bits between the passed-through value and the leading bits of the dropped chunk;
- that garbage on non-first beats and during draining never reaches the result.

The bench sweeps all 64 combinations of L and W and applies backpressure on alternate operands.

// File: rtl/chunk_stage.sv
module chunk_stage #(
  parameter int CW   = 64,
  parameter int MAXC = 8,
  parameter int EW   = 16,
  parameter int FW   = 4,
  parameter int IW   = 2,
  parameter int GW   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [CW-1:0]                 in_data,
  input  logic [$clog2(MAXC+1)-1:0]     in_len,
  input  logic [$clog2(MAXC+1)-1:0]     in_wp,
  input  logic                          in_sign,
  input  logic [FW-1:0]                 in_flags,
  input  logic [EW-1:0]                 in_exp,
  input  logic [IW-1:0]                 in_ib,
  input  logic [GW-1:0]                 in_gb,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [CW-1:0]                 out_data,
  output logic [$clog2(MAXC+1)-1:0]     out_len,
  output logic                          out_last,
  output logic                          out_sign,
  output logic [FW-1:0]                 out_flags,
  output logic [EW-1:0]                 out_exp,
  output logic [IW-1:0]                 out_ib,
  output logic [GW-1:0]                 out_gb
);
  localparam int LW  = $clog2(MAXC+1);
  localparam int IXW = (MAXC > 1) ? $clog2(MAXC) : 1;

  logic [CW-1:0] mbuf [MAXC];
  logic          draining;
  logic [LW-1:0] cnt, len_q, olen_q;
  logic          sign_q;
  logic [FW-1:0] flags_q;
  logic [EW-1:0] exp_q;
  logic [IW-1:0] ib_q;
  logic [GW-1:0] gb_q;

  wire           first    = (cnt == '0);
  wire [LW-1:0]  eff_len  = first ? in_len : len_q;
  wire [LW-1:0]  req_olen = (in_wp < in_len) ? in_wp : in_len;
  wire           in_fire  = in_valid && in_ready;
  wire           out_fire = out_valid && out_ready;
  wire           in_final = in_fire && ((cnt + LW'(1)) == eff_len);
  wire           clamped  = (olen_q < len_q);

  assign in_ready  = !draining;
  assign out_valid = draining;
  assign out_last  = draining && ((cnt + LW'(1)) == olen_q);
  assign out_data  = mbuf[cnt[IXW-1:0]];
  assign out_len   = olen_q;
  assign out_sign  = sign_q;
  assign out_flags = flags_q;
  assign out_exp   = exp_q;
  assign out_ib    = ib_q;
  assign out_gb    = clamped ? mbuf[olen_q[IXW-1:0]][CW-1 -: GW] : gb_q;

  always_ff @(posedge clk)
    if (in_fire) mbuf[cnt[IXW-1:0]] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      draining <= 1'b0;
      cnt      <= '0;
      len_q    <= '0;
      olen_q   <= '0;
      sign_q   <= 1'b0;
      flags_q  <= '0;
      exp_q    <= '0;
      ib_q     <= '0;
      gb_q     <= '0;
    end else if (in_fire) begin
      if (first) begin
        len_q   <= in_len;
        olen_q  <= req_olen;
        sign_q  <= in_sign;
        flags_q <= in_flags;
        exp_q   <= in_exp;
        ib_q    <= in_ib;
      end
      if (in_final) begin
        gb_q     <= in_gb;
        draining <= 1'b1;
        cnt      <= '0;
      end else begin
        cnt <= cnt + LW'(1);
      end
    end else if (out_fire) begin
      if (out_last) begin
        draining <= 1'b0;
        cnt      <= '0;
      end else begin
        cnt <= cnt + LW'(1);
      end
    end
  end

  p_legal_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && first) |-> (in_len != '0 && in_len <= LW'(MAXC) &&
                            in_wp != '0 && in_wp <= LW'(MAXC)));

  p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != '0 && out_len <= LW'(MAXC)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_len) && $stable(out_gb) && $stable(out_last) && $stable(out_exp)));

  p_reopen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> (in_ready && !out_valid));

  p_fill_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_final |=> out_valid);

  p_hdr_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !first) |=> ($stable(out_sign) && $stable(out_flags) &&
                             $stable(out_exp) && $stable(out_ib) && $stable(out_len)));
endmodule

// File: tb/tb_chunk_stage.sv
`timescale 1ns/1ps
module tb_chunk_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [3:0]  in_len = 4'd1, in_wp = 4'd1;
  logic        in_sign = 1'b0;
  logic [3:0]  in_flags = '0;
  logic [15:0] in_exp = '0;
  logic [1:0]  in_ib = '0;
  logic [7:0]  in_gb = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;
  logic [3:0]  out_len;
  logic        out_last, out_sign;
  logic [3:0]  out_flags;
  logic [15:0] out_exp;
  logic [1:0]  out_ib;
  logic [7:0]  out_gb;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chunk_stage dut (.*);

  function automatic logic [63:0] chunk(int op, int i);
    logic [7:0] top = 8'((op * 8 + i) * 37 + 5);
    return {top, 8'(i), 16'(op), 32'hC0DE_0000 ^ 32'(op * 131 + i * 7)};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_op(int op, int l, int w, bit bp);
    int ol = (w < l) ? w : l;
    logic [7:0] gexp;
    logic [63:0] held;
    for (int i = 0; i < l; i++) begin
      in_valid = 1'b1;
      in_data  = chunk(op, i);
      if (i == 0) begin
        in_len = 4'(l); in_wp = 4'(w); in_sign = op[0]; in_flags = 4'(op);
        in_exp = 16'h0100 + 16'(op); in_ib = 2'(op >> 1);
      end else begin
        in_len = 4'hF; in_wp = 4'hF; in_sign = ~op[0]; in_flags = ~4'(op);
        in_exp = 16'hDEAD; in_ib = ~2'(op >> 1);
      end
      in_gb = (i == l - 1) ? 8'(op) ^ 8'hA5 : 8'h5A ^ 8'(i);
      check(in_ready == 1'b1, "R2 ready during fill", 64'(in_ready), 64'd1);
      @(negedge clk);
    end
    // garbage presented during drain must not be taken
    in_data = 64'hBAD0_BAD0_BAD0_BAD0; in_len = 4'd3; in_wp = 4'd2; in_exp = 16'hBEEF;
    in_gb = 8'hEE;
    check(in_ready == 1'b0, "R2 closed after L beats", 64'(in_ready), 64'd0);
    check(out_valid == 1'b1, "R9 result one cycle after last beat", 64'(out_valid), 64'd1);
    gexp = (w < l) ? chunk(op, ol)[63:56] : (8'(op) ^ 8'hA5);
    for (int j = 0; j < ol; j++) begin
      if (bp && (j % 2 == 0)) begin
        out_ready = 1'b0;
        held = out_data;
        @(negedge clk);
        check(out_valid && out_data == held, "R7 hold under backpressure", out_data, held);
        check(in_ready == 1'b0, "R6 no input while stalled", 64'(in_ready), 64'd0);
      end
      out_ready = 1'b1;
      check(out_valid == 1'b1, "R3 chunk offered", 64'(out_valid), 64'd1);
      check(out_data == chunk(op, j), "R3 chunk data/order", out_data, chunk(op, j));
      check(out_last == (j == ol - 1), "R3 last flag", 64'(out_last), 64'(j == ol - 1));
      check(in_ready == 1'b0, "R6 input blocked while draining", 64'(in_ready), 64'd0);
      if (j == ol - 1) begin
        check(out_len == 4'(ol), "R3 clamped length", 64'(out_len), 64'(ol));
        check(out_sign == op[0] && out_flags == 4'(op) && out_ib == 2'(op >> 1),
              "R4 header copy", {out_sign, out_flags, out_ib}, {op[0], 4'(op), 2'(op >> 1)});
        check(out_exp == 16'h0100 + 16'(op), "R8 R4 exponent from first beat",
              64'(out_exp), 64'(16'h0100 + 16'(op)));
        check(out_gb == gexp, "R5 guard bits", 64'(out_gb), 64'(gexp));
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    in_valid  = 1'b0;
    check(in_ready == 1'b1 && out_valid == 1'b0, "R6 reopen after last",
          {in_ready, out_valid}, 64'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset state", {in_ready, out_valid}, 64'b10);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset", {in_ready, out_valid}, 64'b10);
    for (int l = 1; l <= 8; l++)
      for (int w = 1; w <= 8; w++)
        run_op((l - 1) * 8 + (w - 1), l, w, bit'(w % 2));
    // R9: unstalled occupancy is L + min(L,W) cycles
    begin
      int cyc = 0;
      in_valid = 1'b1; out_ready = 1'b1;
      in_len = 4'd5; in_wp = 4'd3; in_data = 64'h1;
      @(negedge clk);
      in_len = 4'hF;
      cyc = 1;
      while (!(out_valid && out_last) && cyc < 50) begin @(negedge clk); cyc++; end
      @(negedge clk); cyc++;
      in_valid = 1'b0;
      check(cyc == 8, "R9 occupancy L+min(L,W)", 64'(cyc), 64'd8);
      check(in_ready == 1'b1, "R9 R6 free after operand", 64'(in_ready), 64'd1);
      out_ready = 1'b0;
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule